// File: doc/BRIEF.md
# High/Low Ratio Channel Arbiter

This block decides which of eight DMA channels gets the next single-unit transfer slot. Every channel presents a request bit, a pause bit and a class bit that marks it as high or low priority. The arbiter issues one registered one-hot grant at a time and holds it until the channel datapath pulses a transfer-done strobe. Arbitration therefore happens once per unit transfer, not once per buffer.

A ratio input sets how many high-class grants may be issued in a row before a waiting low-class channel must be served. This keeps low channels from being starved while high channels keep requesting. A ratio of zero removes the class distinction, and all eligible channels then share one round-robin rotation. The legal ratio values have the form 2^k-1 (0, 1, 3, 7 … 255). Any other value behaves as the next lower legal value.

The block fits between per-channel request logic and a shared transfer engine. Channel datapaths and the bus interface are outside it.

Top module: `ratio_arbiter`

## Requirements
- R1: After a synchronous reset, `grant` is all zeros and `grant_valid` is 0. The rotation pointers (high, low and shared) are set so that the first grant of each rotation goes to the lowest-numbered eligible channel.
- R2: A channel is eligible when `req[i]=1` and `pause[i]=0`. A grant is always one-hot (bit i = channel i) and goes only to an eligible channel. With no eligible channel, `grant_valid` stays 0.
- R3: A grant holds, unchanged, until `xfer_done` is sampled high. `grant_valid` falls at that edge. The next decision uses the inputs of the following cycle, and a new grant appears one edge later. Input changes while a grant is held have no effect on it.
- R4: A paused channel is never granted, even while its request is high. Clearing the pause makes it eligible for the next decision.
- R5: Within one class, the next grant goes to the first eligible channel of that class after the last channel granted in that class, wrapping from 7 to 0.
- R6: With a nonzero effective ratio N and both classes eligible, N high-class grants are followed by one low-class grant. `hi_pri[i]=1` marks channel i as high class. With N=1, grants alternate between the classes.
- R7: While no low channel is eligible, high channels keep getting grants and the count of high grants saturates instead of wrapping. The first decision that sees a low channel, after at least N high grants, serves that low channel. The count then restarts from zero.
- R8: While no high channel is eligible, low channels are served back to back. Each grant follows the previous release after the one decision cycle of R3 and no extra wait.
- R9: When the effective ratio is 0, every eligible channel takes part in one shared rotation that starts after the last channel granted, regardless of class.
- R10: A ratio value that is not of the form 2^k-1 acts as the largest legal value below it. For example, 5 acts as 3.
- R11: A `xfer_done` pulse while no grant is held is ignored, and the next request is granted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_CH | Per-channel transfer request |
| hi_pri | input | NUM_CH | Per-channel class, 1 = high |
| pause | input | NUM_CH | Per-channel pause, masks the request |
| ratio | input | RATIO_W | High-to-low grant ratio, 0 = shared round robin |
| xfer_done | input | 1 | Strobe: the granted unit transfer has finished |
| grant | output | NUM_CH | One-hot registered grant |
| grant_valid | output | 1 | A grant is held |

## Verification
The bench checks the exact grant order under several ratios. A counter that compares with the wrong bound, or resets at the wrong time, would shift where the low slot lands or would never issue it. It feeds an illegal ratio of 5 and expects three high grants per low grant. A design that uses the raw value or rounds it up would give five or seven. A saturation scenario runs high channels alone and then adds a low request. A wrapping counter would then keep the low channel waiting. Further scenarios cover held grants under changing requests, paused requests, a stray done strobe and a mixed-class shared rotation. These catch a grant that moves or drops early, a paused channel being served, and per-class pointers wrongly used in shared mode.

// File: rtl/ratio_arb_pkg.sv
package ratio_arb_pkg;
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_HIGH = 2'd1,
    PICK_LOW  = 2'd2,
    PICK_ANY  = 2'd3
  } pick_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Search the candidates in rotation order, beginning just past 'last'.
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last) + off) % N;
      if (!found && mask[cand]) begin
        found = 1'b1;
        idx   = IW'(cand);
      end
    end
  end

  // R5: a pick always lands on a set mask bit, and any set bit gets picked.
  always_comb begin
    if (found) assert_pick_in_mask_R5: assert (mask[idx]);
    assert_pick_found_R5: assert (found == (|mask));
  end
endmodule

// File: rtl/ratio_norm.sv
module ratio_norm #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] eff
);
  // Round down to the form 2^k-1: smear (raw+1) downward, then drop one bit.
  logic [W:0] inc;
  logic [W:0] sm;
  always_comb begin
    inc = {1'b0, raw} + 1'b1;
    sm  = inc;
    for (int i = 0; i < W; i++) sm = sm | (sm >> 1);
    eff = sm[W:1];
  end

  // R10: the result is legal and never above the input.
  always_comb begin
    assert_norm_legal_R10: assert (((eff + 1'b1) & eff) == '0);
    assert_norm_not_above_R10: assert (eff <= raw);
  end
endmodule

// File: rtl/ratio_arbiter.sv
module ratio_arbiter #(
  parameter int NUM_CH  = 8,
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  req,
  input  logic [NUM_CH-1:0]  hi_pri,
  input  logic [NUM_CH-1:0]  pause,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               xfer_done,
  output logic [NUM_CH-1:0]  grant,
  output logic               grant_valid
);
  import ratio_arb_pkg::*;

  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IW-1:0] PTR_INIT = IW'(NUM_CH - 1);

  logic [NUM_CH-1:0]  elig, hi_m, lo_m, onehot;
  logic [IW-1:0]      last_hi, last_lo, last_all;
  logic [IW-1:0]      hi_idx, lo_idx, all_idx, pick_idx;
  logic               hi_found, lo_found, all_found;
  logic [RATIO_W-1:0] eff, hi_cnt;
  pick_e              sel;

  assign elig = req & ~pause;
  assign hi_m = elig & hi_pri;
  assign lo_m = elig & ~hi_pri;

  ratio_norm #(.W(RATIO_W)) u_norm (.raw(ratio), .eff(eff));

  rr_pick #(.N(NUM_CH), .IW(IW)) u_hi  (.mask(hi_m), .last(last_hi),  .found(hi_found),  .idx(hi_idx));
  rr_pick #(.N(NUM_CH), .IW(IW)) u_lo  (.mask(lo_m), .last(last_lo),  .found(lo_found),  .idx(lo_idx));
  rr_pick #(.N(NUM_CH), .IW(IW)) u_all (.mask(elig), .last(last_all), .found(all_found), .idx(all_idx));

  // Decision: made only while no grant is held.
  always_comb begin
    sel = PICK_NONE;
    if (!grant_valid && all_found) begin
      if (eff == '0)                 sel = PICK_ANY;
      else if (hi_found && lo_found) sel = (hi_cnt >= eff) ? PICK_LOW : PICK_HIGH;
      else if (hi_found)             sel = PICK_HIGH;
      else                           sel = PICK_LOW;
    end
  end

  always_comb begin
    unique case (sel)
      PICK_HIGH: pick_idx = hi_idx;
      PICK_LOW:  pick_idx = lo_idx;
      default:   pick_idx = all_idx;
    endcase
    onehot = '0;
    onehot[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      grant_valid <= 1'b0;
      last_hi     <= PTR_INIT;
      last_lo     <= PTR_INIT;
      last_all    <= PTR_INIT;
      hi_cnt      <= '0;
    end else if (grant_valid) begin
      if (xfer_done) begin
        grant       <= '0;
        grant_valid <= 1'b0;
      end
    end else if (sel != PICK_NONE) begin
      grant       <= onehot;
      grant_valid <= 1'b1;
      last_all    <= pick_idx;
      if (hi_pri[pick_idx]) last_hi <= pick_idx;
      else                  last_lo <= pick_idx;
      if (sel == PICK_ANY || sel == PICK_LOW) hi_cnt <= '0;
      else if (hi_cnt != '1)                  hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2: one-hot while valid, empty otherwise.
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($countones(grant) == 1));
  assert_empty_R2: assert property (@(posedge clk) disable iff (rst)
    !grant_valid |-> (grant == '0));
  // R4: a fresh grant targets a channel that was eligible in the decision cycle.
  assert_eligible_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> ((grant & $past(req & ~pause)) != '0));
  // R3: hold without done, release on done.
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant)));
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && xfer_done) |=> !grant_valid);
  // R7: the high-grant count never wraps to zero on a high grant.
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == PICK_HIGH && hi_cnt == '1) |=> (hi_cnt == '1));
endmodule

// File: tb/tb_ratio_arbiter.sv
module tb_ratio_arbiter;
  localparam int NUM_CH = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req, hi_pri, pause, ratio;
  logic       xfer_done;
  logic [7:0] grant;
  logic       grant_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ratio_arbiter #(.NUM_CH(NUM_CH), .RATIO_W(8)) dut (
    .clk(clk), .rst(rst), .req(req), .hi_pri(hi_pri), .pause(pause),
    .ratio(ratio), .xfer_done(xfer_done), .grant(grant), .grant_valid(grant_valid));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = '0; hi_pri = '0; pause = '0; ratio = '0; xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // At a negedge: expect a valid grant on channel ch.
  task automatic expect_grant(input int ch, input string tag);
    logic [7:0] e;
    e = 8'(1 << ch);
    chk(grant_valid && grant == e, tag, {23'd0, grant_valid, grant}, {23'd0, 1'b1, e});
  endtask

  // Pulse done, check release, land on the negedge where the next grant shows.
  task automatic release_grant(input string tag);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(!grant_valid, {tag, " release"}, {31'd0, grant_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic take(input int ch, input string tag);
    expect_grant(ch, tag);
    release_grant(tag);
  endtask

  task automatic t_reset();
    do_reset();
    chk(grant == '0 && !grant_valid, "R1 reset state", {23'd0, grant_valid, grant}, 32'd0);
  endtask

  task automatic t_idle_done();
    do_reset();
    repeat (3) @(negedge clk);
    chk(!grant_valid, "R2 no request no grant", {31'd0, grant_valid}, 32'd0);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(!grant_valid, "R11 stray done ignored", {31'd0, grant_valid}, 32'd0);
    req = 8'h08;
    @(negedge clk);
    take(3, "R11 grant after stray done");
  endtask

  task automatic t_hold();
    do_reset();
    req = 8'h10;
    @(negedge clk);
    expect_grant(4, "R3 first grant");
    req = 8'h03;
    repeat (3) begin
      @(negedge clk);
      expect_grant(4, "R3 held while inputs change");
    end
    release_grant("R3 hold");
    expect_grant(0, "R3 next grant one cycle after release");
    release_grant("R3 tail");
  endtask

  task automatic t_low_only();
    do_reset();
    ratio = 8'd3; req = 8'h52;
    @(negedge clk);
    take(1, "R8 low only 1");
    take(4, "R8 low only 4");
    take(6, "R8 low only 6");
    take(1, "R5 low wraps to 1");
  endtask

  task automatic t_ratio3();
    do_reset();
    ratio = 8'd3; hi_pri = 8'h05; req = 8'h25;
    @(negedge clk);
    take(0, "R6 r3 H0");
    take(2, "R6 r3 H2");
    take(0, "R6 r3 H0 again");
    take(5, "R6 r3 L5");
    take(2, "R5 r3 high resumes at 2");
    take(0, "R6 r3 H0");
    take(2, "R6 r3 H2");
    take(5, "R6 r3 L5 second");
  endtask

  task automatic t_ratio1();
    do_reset();
    ratio = 8'd1; hi_pri = 8'h0A; req = 8'h9A;
    @(negedge clk);
    take(1, "R6 r1 H1");
    take(4, "R6 r1 L4");
    take(3, "R6 r1 H3");
    take(7, "R6 r1 L7");
    take(1, "R5 r1 H1 wrap");
  endtask

  task automatic t_illegal();
    do_reset();
    ratio = 8'd5; hi_pri = 8'h01; req = 8'h03;
    @(negedge clk);
    take(0, "R10 ratio5 H");
    take(0, "R10 ratio5 H");
    take(0, "R10 ratio5 H");
    take(1, "R10 ratio5 acts as 3, low slot");
    take(0, "R10 ratio5 H after low");
  endtask

  task automatic t_saturate();
    do_reset();
    ratio = 8'd3; hi_pri = 8'h04; req = 8'h04;
    @(negedge clk);
    for (int i = 0; i < 6; i++) take(2, "R7 high alone");
    expect_grant(2, "R7 seventh high");
    req = 8'h44;
    release_grant("R7 seventh");
    take(6, "R7 low served after long high run");
    take(2, "R7 count restarted");
  endtask

  task automatic t_shared();
    do_reset();
    ratio = 8'd0; hi_pri = 8'h42; req = 8'h4A;
    @(negedge clk);
    take(1, "R9 shared 1");
    take(3, "R9 shared 3 low in rotation");
    take(6, "R9 shared 6");
    take(1, "R9 shared wrap 1");
  endtask

  task automatic t_pause();
    do_reset();
    ratio = 8'd0; req = 8'h05; pause = 8'h01;
    @(negedge clk);
    take(2, "R4 paused 0 skipped");
    expect_grant(2, "R4 paused 0 skipped again");
    req = 8'h01;
    release_grant("R4");
    repeat (2) begin
      chk(!grant_valid, "R4 only paused request", {31'd0, grant_valid}, 32'd0);
      @(negedge clk);
    end
    pause = 8'h00;
    @(negedge clk);
    take(0, "R4 unpaused granted");
  endtask

  initial begin
    t_reset();
    t_idle_done();
    t_hold();
    t_low_only();
    t_ratio3();
    t_ratio1();
    t_illegal();
    t_saturate();
    t_shared();
    t_pause();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule